// File: doc/BRIEF.md
# Lockable Transient-Aware Victim Selector

This block picks which way of a set-associative cache receives a line fill. A fill request names a set and carries a per-page transient attribute. The block answers one cycle later with the way to replace, or with a no-victim flag when nothing may be replaced. Tag arrays, data arrays and the fill sequencer sit outside the block; the fill engine simply waits for the response.

Two pieces of configuration constrain the choice. First, software may lock groups of lines. The size of a group depends on the configured cache size: 16 lines for the large size, and 8 lines for the small and medium sizes. A locked group is never chosen. Second, a programmable window of ways is reserved for transient fills. Transient fills land only inside the window, and ordinary fills land only outside it. This keeps streaming content from displacing the regular working set. Each set keeps its own round-robin pointer for ordinary fills. A single shared round-robin pointer serves transient fills.

Both configuration values sit in registers behind a plain write port. A write becomes visible to any request issued in a later cycle.

Top module: `vsel_top`

## Requirements
- R1: A request (req_valid high at a rising edge) produces rsp_valid high in the next cycle with its result. Without a request, rsp_valid is low in the next cycle, and no_victim is only ever high together with rsp_valid.
- R2: size_sel encodes the cache size: 0 = small, 1 = medium, 2 or 3 = large. These sizes have 8, 16 and 32 active sets. req_set is reduced to its low bits to fit the active set count. At the large size a lock group is 16 lines, and way w in set s uses lock bit w*2 + s[4].
- R3: At the medium size a lock group is 8 lines, and way w in set s uses lock bit w*2 + s[3]. At the small size a lock group is 8 lines, and way w uses lock bit w in every set.
- R4: A way whose lock bit is set is never returned as a victim.
- R5: A transient request may only receive a way w with lo <= w <= hi. When lo > hi the window is empty.
- R6: An ordinary request may only receive a way outside the window [lo, hi].
- R7: Each set keeps its own ordinary pointer. The victim is the first candidate way at or after the pointer, searching upward with wrap-around, and after a grant the pointer becomes victim+1 modulo the number of ways.
- R8: Transient requests use one pointer shared by all sets, with the same search and update rule as R7.
- R9: When no way is a candidate, no_victim is 1, victim_way is 0, and neither pointer changes.
- R10: A config write with cfg_addr 0 loads the lock register from cfg_wdata[15:0]. A write with cfg_addr 1 loads lo from cfg_wdata[2:0] and hi from cfg_wdata[10:8]. A write takes effect on any request issued in a later cycle.
- R11: After reset the lock register is 0, lo = hi = 7, all pointers are 0, and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_sel | input | 2 | Cache size configuration |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 1 | Config register select: 0 lock, 1 window |
| cfg_wdata | input | 16 | Config write data |
| req_valid | input | 1 | Fill request |
| req_set | input | 5 | Set index of the fill |
| req_transient | input | 1 | Page carries the transient attribute |
| rsp_valid | output | 1 | Result valid, one cycle after a request |
| victim_way | output | 3 | Selected way |
| no_victim | output | 1 | No replaceable way exists |

## Verification
The hardest state to reach is a no-victim response that leaves the shared transient pointer untouched. Reaching it needs the transient pointer advanced to a non-zero position, every group locked, and the lock then released before the effect shows at the ports. The stimulus first walks several transient grants through a three-way window, then locks everything and issues both request kinds. It then unlocks and checks that the next transient victim is exactly where the pointer stood before. Granularity is told apart by reusing one lock pattern across the three sizes with set indices whose bit 3 and bit 4 differ.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    SZ_SMALL = 2'd0,
    SZ_MED   = 2'd1,
    SZ_LARGE = 2'd2,
    SZ_ALT   = 2'd3
  } size_e;

  localparam logic CFG_LOCK = 1'b0;
  localparam logic CFG_WIN  = 1'b1;
endpackage

// File: rtl/vsel_cfg_regs.sv
module vsel_cfg_regs #(
  parameter int WAYS   = 8,
  parameter int LOCK_W = 16,
  parameter int CFG_DW = 16,
  localparam int WAYW  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [LOCK_W-1:0] lock_q,
  output logic [WAYW-1:0]   lo_q,
  output logic [WAYW-1:0]   hi_q
);
  import vsel_pkg::*;

  logic [LOCK_W-1:0] lock_d;
  logic [WAYW-1:0]   lo_d, hi_d;
  logic              lock_en, win_en;

  assign lock_en = cfg_we && (cfg_addr == CFG_LOCK);
  assign win_en  = cfg_we && (cfg_addr == CFG_WIN);

  always_comb begin
    lock_d = lock_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (lock_en) lock_d = cfg_wdata[LOCK_W-1:0];
    if (win_en) begin
      lo_d = cfg_wdata[WAYW-1:0];
      hi_d = cfg_wdata[8+WAYW-1:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      lo_q   <= WAYW'(WAYS-1);
      hi_q   <= WAYW'(WAYS-1);
    end else begin
      lock_q <= lock_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end
endmodule

// File: rtl/vsel_cand_mask.sv
module vsel_cand_mask #(
  parameter int WAYS   = 8,
  parameter int SETS   = 32,
  parameter int LOCK_W = 16,
  localparam int WAYW  = $clog2(WAYS),
  localparam int SETW  = $clog2(SETS)
) (
  input  logic [1:0]        size_sel,
  input  logic [SETW-1:0]   set_in,
  input  logic              transient,
  input  logic [LOCK_W-1:0] lock,
  input  logic [WAYW-1:0]   lo,
  input  logic [WAYW-1:0]   hi,
  output logic [SETW-1:0]   eff_set,
  output logic [WAYS-1:0]   cand
);
  import vsel_pkg::*;

  localparam int SETS_SM = SETS / 4;
  localparam int SETS_MD = SETS / 2;
  localparam int SH_SMALL = 3;
  localparam int SH_LARGE = 4;

  int          sets_act;
  int          shift;
  int          grp_in_way;
  int          gpw;
  logic [WAYS-1:0] locked;
  logic [WAYS-1:0] in_win;

  always_comb begin
    case (size_e'(size_sel))
      SZ_SMALL: begin sets_act = SETS_SM; shift = SH_SMALL; end
      SZ_MED:   begin sets_act = SETS_MD; shift = SH_SMALL; end
      default:  begin sets_act = SETS;    shift = SH_LARGE; end
    endcase
    eff_set    = set_in & SETW'(sets_act - 1);
    grp_in_way = int'(eff_set) >> shift;
    gpw        = sets_act >> shift;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LOCK_W-1:0] lock_sh;
    assign lock_sh   = lock >> (w * gpw + grp_in_way);
    assign locked[w] = lock_sh[0];
    assign in_win[w] = (WAYW'(w) >= lo) && (WAYW'(w) <= hi);
    assign cand[w]   = !locked[w] && (transient ? in_win[w] : !in_win[w]);
  end
endmodule

// File: rtl/vsel_rr_pick.sv
module vsel_rr_pick #(
  parameter int WAYS  = 8,
  localparam int WAYW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] cand,
  input  logic [WAYW-1:0] ptr,
  output logic            found,
  output logic [WAYW-1:0] way
);
  logic [WAYW-1:0] idx;

  always_comb begin
    found = 1'b0;
    way   = '0;
    idx   = '0;
    for (int i = 0; i < WAYS; i++) begin
      idx = ptr + WAYW'(i);
      if (!found && cand[idx]) begin
        found = 1'b1;
        way   = idx;
      end
    end
  end
endmodule

// File: rtl/vsel_top.sv
module vsel_top #(
  parameter int WAYS   = 8,
  parameter int SETS   = 32,
  parameter int CFG_DW = 16,
  localparam int LOCK_W = WAYS * SETS / 16,
  localparam int WAYW   = $clog2(WAYS),
  localparam int SETW   = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        size_sel,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [SETW-1:0]   req_set,
  input  logic              req_transient,
  output logic              rsp_valid,
  output logic [WAYW-1:0]   victim_way,
  output logic              no_victim
);
  logic [LOCK_W-1:0] lock_q;
  logic [WAYW-1:0]   lo_q, hi_q;
  logic [SETW-1:0]   eff_set;
  logic [WAYS-1:0]   cand;
  logic              found;
  logic [WAYW-1:0]   pick_way;
  logic [WAYW-1:0]   cur_ptr;

  logic [WAYW-1:0]   nptr_q [SETS];
  logic [WAYW-1:0]   nptr_d [SETS];
  logic [WAYW-1:0]   tptr_q, tptr_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic [WAYW-1:0]   victim_q, victim_d;
  logic              nv_q, nv_d;

  vsel_cfg_regs #(.WAYS(WAYS), .LOCK_W(LOCK_W), .CFG_DW(CFG_DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lock_q(lock_q), .lo_q(lo_q), .hi_q(hi_q)
  );

  vsel_cand_mask #(.WAYS(WAYS), .SETS(SETS), .LOCK_W(LOCK_W)) u_mask (
    .size_sel(size_sel), .set_in(req_set), .transient(req_transient),
    .lock(lock_q), .lo(lo_q), .hi(hi_q), .eff_set(eff_set), .cand(cand)
  );

  assign cur_ptr = req_transient ? tptr_q : nptr_q[eff_set];

  vsel_rr_pick #(.WAYS(WAYS)) u_pick (
    .cand(cand), .ptr(cur_ptr), .found(found), .way(pick_way)
  );

  always_comb begin
    nptr_d      = nptr_q;
    tptr_d      = tptr_q;
    rsp_valid_d = req_valid;
    victim_d    = victim_q;
    nv_d        = req_valid && !found;
    if (req_valid) begin
      victim_d = found ? pick_way : '0;
      if (found) begin
        if (req_transient) tptr_d = pick_way + 1'b1;
        else               nptr_d[eff_set] = pick_way + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) nptr_q[s] <= '0;
      tptr_q      <= '0;
      rsp_valid_q <= 1'b0;
      victim_q    <= '0;
      nv_q        <= 1'b0;
    end else begin
      nptr_q      <= nptr_d;
      tptr_q      <= tptr_d;
      rsp_valid_q <= rsp_valid_d;
      victim_q    <= victim_d;
      nv_q        <= nv_d;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign victim_way = victim_q;
  assign no_victim  = nv_q;
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
  parameter int WAYS  = 8,
  localparam int WAYW = $clog2(WAYS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_transient,
  input logic [WAYS-1:0] cand,
  input logic [WAYW-1:0] lo_q,
  input logic [WAYW-1:0] hi_q,
  input logic            rsp_valid,
  input logic [WAYW-1:0] victim_way,
  input logic            no_victim
);
  logic [WAYS-1:0] cand_p;
  logic            trans_p;
  logic [WAYW-1:0] lo_p, hi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_p  <= '0;
      trans_p <= 1'b0;
      lo_p    <= '0;
      hi_p    <= '0;
    end else if (req_valid) begin
      cand_p  <= cand;
      trans_p <= req_transient;
      lo_p    <= lo_q;
      hi_p    <= hi_q;
    end
  end

  assert_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_nv_with_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    no_victim |-> rsp_valid);
  assert_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !no_victim) |-> cand_p[victim_way]);
  assert_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && trans_p && !no_victim) |-> (victim_way >= lo_p && victim_way <= hi_p));
  assert_out_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !trans_p && !no_victim) |-> !(victim_way >= lo_p && victim_way <= hi_p));
  assert_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && no_victim) |-> (cand_p == '0 && victim_way == '0));
endmodule

bind vsel_top vsel_checker #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_transient(req_transient),
  .cand(cand), .lo_q(lo_q), .hi_q(hi_q), .rsp_valid(rsp_valid),
  .victim_way(victim_way), .no_victim(no_victim)
);

// File: tb/vsel_top_tb.sv
module vsel_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = 2'd2;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_set = '0;
  logic        req_transient = 1'b0;
  logic        rsp_valid;
  logic [2:0]  victim_way;
  logic        no_victim;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vsel_top u_dut (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_set(req_set), .req_transient(req_transient), .rsp_valid(rsp_valid),
    .victim_way(victim_way), .no_victim(no_victim)
  );

  // {set[4:0], transient, expected way[2:0], expected no_victim}, large size, reset config
  localparam logic [9:0] VEC [6] = '{
    {5'd0, 1'b0, 3'd0, 1'b0},
    {5'd0, 1'b0, 3'd1, 1'b0},
    {5'd1, 1'b0, 3'd0, 1'b0},
    {5'd0, 1'b1, 3'd7, 1'b0},
    {5'd0, 1'b1, 3'd7, 1'b0},
    {5'd0, 1'b0, 3'd2, 1'b0}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_req(input int s, input bit tr);
    @(negedge clk);
    req_valid = 1'b1; req_set = s[4:0]; req_transient = tr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_way(input string tag, input int s, input bit tr, input int w);
    do_req(s, tr);
    check(tag, int'(rsp_valid), 1);
    check(tag, int'(no_victim), 0);
    check(tag, int'(victim_way), w);
  endtask

  task automatic expect_none(input string tag, input int s, input bit tr);
    do_req(s, tr);
    check(tag, int'(rsp_valid), 1);
    check(tag, int'(no_victim), 1);
    check(tag, int'(victim_way), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state / R1 idle
    check("R11 rsp_valid after reset", int'(rsp_valid), 0);
    check("R1 no_victim idle", int'(no_victim), 0);

    // R7 R8 R11 table: default window is way 7 only, pointers start at 0
    for (int i = 0; i < 6; i++) begin
      expect_way($sformatf("R7/R8 vector %0d", i), int'(VEC[i][9:5]), VEC[i][4], int'(VEC[i][3:1]));
    end
    @(negedge clk);
    check("R1 idle after request", int'(rsp_valid), 0);

    // R10 R5 R8: window 4..6, shared transient pointer wraps inside it
    cfg_write(1'b1, 16'h0604);
    expect_way("R5 transient first", 2, 1'b1, 4);
    expect_way("R8 transient next", 9, 1'b1, 5);
    expect_way("R8 transient next2", 2, 1'b1, 6);
    expect_way("R8 transient wrap", 2, 1'b1, 4);
    // R6: ordinary request skips the window
    expect_way("R6 ordinary outside window", 2, 1'b0, 0);

    // R2 R4: large size, lock bits 0 and 2 = ways 0 and 1 for sets with bit4 clear
    cfg_write(1'b0, 16'h0005);
    expect_way("R2 large locked half", 3, 1'b0, 2);
    expect_way("R2 large other half", 20, 1'b0, 0);
    // R3: medium, set 8 has bit3 set -> unlocked
    size_sel = 2'd1;
    expect_way("R3 medium set bit3", 8, 1'b0, 0);
    // R3: small, ways 0 and 2 locked in every set
    size_sel = 2'd0;
    expect_way("R3 small way lock", 6, 1'b0, 1);

    // R9: everything locked, pointers must not move
    cfg_write(1'b0, 16'h00FF);
    expect_none("R9 ordinary none", 6, 1'b0);
    expect_none("R9 transient none", 6, 1'b1);
    cfg_write(1'b0, 16'h0000);
    expect_way("R9 transient ptr kept", 6, 1'b1, 5);
    // R4 with transient: ways 4,5 locked
    cfg_write(1'b0, 16'h0030);
    expect_way("R4 transient skip locked", 6, 1'b1, 6);
    expect_way("R4 transient wrap to 6", 6, 1'b1, 6);

    // R5: empty window (lo 6 > hi 2)
    size_sel = 2'd2;
    cfg_write(1'b0, 16'h0000);
    cfg_write(1'b1, 16'h0206);
    expect_none("R5 empty window transient", 11, 1'b1);
    expect_way("R6 empty window ordinary", 11, 1'b0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule